// File: doc/BRIEF.md
# Serial Peripheral Port with Master and Slave Modes

This block is an 8-bit serial peripheral interface with a two-register CPU-side port. The control register chooses the role, the bit rate, the bit order and the select-line handling, and it holds two sticky flags. The data register accepts a byte to transmit and returns the last byte received. One shift buffer carries each byte out on SDO while the incoming byte enters it from SDI.

As a master, a write to the data register starts an 8-bit transfer at once. SCK is generated from the system clock through a prescaler and a mode-selected divider. As a slave, the block follows SCK and the select line from an external master, after resynchronising them into the system clock domain. Timing is fixed to clock mode 0. Every pin that can be driven has an output enable, so the lines float when the port is off.

Top module: `spi_xfer_unit`

## Requirements
- R1: After reset the control register reads 0x60, which is slave mode with every other bit 0. All three output enables are low.
- R2: The control register bits are: [7] clock-fast, [6:5] mode, [4] bus enable, [3] MSB-first, [2] select enable, [1] collision flag, [0] complete flag. A write sets bits 7:2 to the written value, and a read of bus_sel=0 returns all eight bits.
- R3: SCK idles low. In master mode each SCK half-period lasts P*D system cycles. P is 1 when clock-fast=1 and 4 when it is 0. D is 1, 4 or 16 for mode 00, 01 or 10. The first rising edge comes P*D cycles after the clock edge that captures the data write.
- R4: MSB-first=1 sends and receives bit 7 first. MSB-first=0 sends and receives bit 0 first.
- R5: SDO changes only on SCK falling edges, and SDI is sampled on SCK rising edges. While a master transfer runs, SDO shows transmit bit k after the k-th falling edge.
- R6: With bus enable=0, sck_oe, sdo_oe and scs_oe are all low. As master with bus enable=1, sck_oe and sdo_oe are high, and scs_oe equals select enable.
- R7: As master with select enable=1, scs_o is low for the whole transfer and high otherwise.
- R8: The complete flag is set on the 8th SCK falling edge, 16*P*D cycles after the write in master mode. A read with bus_sel=1 then returns the received byte.
- R9: A data write during a transfer sets the collision flag and is discarded. The transfer in progress carries on unchanged.
- R10: Writing 0 to bit 1 or bit 0 of the control register clears that flag. Writing 1 leaves the flag as it was.
- R11: With bus enable=0, a data write loads the shift buffer but starts no transfer.
- R12: In mode 11 the block drives no SCK. It shifts on the external SCK after a two-flop synchronizer, and it sets the complete flag and the received byte after 8 external bits.
- R13: In mode 11 with select enable=1, SCK edges are ignored while scs_i is high, and SDO floats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 control, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Output enable for sck_o |
| scs_i | input | 1 | Select line from an external master, active low |
| scs_o | output | 1 | Select line driven as master, active low |
| scs_oe | output | 1 | Output enable for scs_o |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo_o |

## Verification
A register write is visible the cycle after the edge that captures it. In master mode, SCK level and SDO follow from the count of edges since the data write: the level is odd or even in units of P*D, and the complete flag lands at 16*P*D. A behavioural model advances that count on every rising edge, and the bench compares each output a quarter period later, so every registered change has settled. In slave mode the synchronizer adds about three cycles after each external edge, so the bench holds each SCK phase for eight cycles and samples SDO and the flags only at the end of a phase.

// File: rtl/spi_xfer_pkg.sv
// Shared types for the serial port: mode encoding and control register view.
// Assumes an 8-bit register port; bit positions of the control register are
// fixed by software decoding.
package spi_xfer_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        MODE_FAST  = 2'b00,
        MODE_MID   = 2'b01,
        MODE_SLOW  = 2'b10,
        MODE_SLAVE = 2'b11
    } spi_mode_e;

    typedef struct packed {
        logic      clk_fast;
        spi_mode_e mode;
        logic      bus_en;
        logic      msb_first;
        logic      sel_en;
        logic      collide;
        logic      done;
    } spi_ctrl_t;

    localparam logic [REG_W-1:0] CTRL_RESET = 8'h60;

endpackage

// File: rtl/spi_xfer_clkdiv.sv
// Half-period tick generator for master SCK.
// Emits one tick every PRESCALE*D cycles (or D when clk_fast) while run is high.
// D is picked by the mode field. The counter restarts whenever run is low.
module spi_xfer_clkdiv
    import spi_xfer_pkg::*;
#(
    parameter int PRESCALE = 4,
    parameter int DIV_MID  = 4,
    parameter int DIV_SLOW = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      clk_fast,
    input  spi_mode_e mode,
    output logic      tick
);
    localparam int MAX_HALF = PRESCALE * DIV_SLOW;
    localparam int CW       = $clog2(MAX_HALF + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] half_m1;

    // Terminal count for the selected prescale and divider pair
    always_comb begin
        int unsigned pre;
        int unsigned div;
        pre = clk_fast ? 1 : PRESCALE;
        case (mode)
            MODE_FAST: div = 1;
            MODE_MID:  div = DIV_MID;
            default:   div = DIV_SLOW;
        endcase
        half_m1 = CW'(pre * div - 1);
    end

    assign tick = run && (cnt == half_m1);

    // Cycle counter within one SCK half-period
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    // R3: a new transfer always starts from a full half-period
    a_r3_restart_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt == '0));

endmodule

// File: rtl/spi_xfer_sync.sv
// Brings external SCK and select into the system clock domain.
// Gives single-cycle rise and fall pulses and a synchronized select level.
// Assumes the system clock is at least four times the external SCK rate.
module spi_xfer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_raw,
    input  logic scs_raw,
    output logic sck_rise,
    output logic sck_fall,
    output logic scs_level
);
    logic [STAGES:0]   sck_pipe;
    logic [STAGES-1:0] scs_pipe;

    // Shift raw lines through the synchronizer, one extra SCK stage for edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe <= '0;
            scs_pipe <= '1;
        end else begin
            sck_pipe <= {sck_pipe[STAGES-1:0], sck_raw};
            scs_pipe <= {scs_pipe[STAGES-2:0], scs_raw};
        end
    end

    assign sck_rise  =  sck_pipe[STAGES-1] && !sck_pipe[STAGES];
    assign sck_fall  = !sck_pipe[STAGES-1] &&  sck_pipe[STAGES];
    assign scs_level =  scs_pipe[STAGES-1];

    // R12: each detected external edge is a one-cycle pulse
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> !sck_rise);

endmodule

// File: rtl/spi_xfer_shifter.sv
// Single shift buffer shared by transmit and receive.
// Samples on sample_evt, shifts on shift_evt, and flags the last shift.
// Assumes sample and shift events alternate, starting with a sample.
module spi_xfer_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         abort,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         start,
    input  logic         msb_first,
    input  logic         sample_evt,
    input  logic         sample_in,
    input  logic         shift_evt,
    output logic         out_bit,
    output logic         active,
    output logic         done_evt,
    output logic [W-1:0] rx_data
);
    localparam int CNTW = $clog2(W);

    logic [W-1:0]    sbuf;
    logic [W-1:0]    shifted;
    logic [W-1:0]    rx_q;
    logic [CNTW-1:0] nbits;
    logic            samp;
    logic            active_q;

    assign shifted  = msb_first ? {sbuf[W-2:0], samp} : {samp, sbuf[W-1:1]};
    assign out_bit  = msb_first ? sbuf[W-1] : sbuf[0];
    assign done_evt = !abort && active_q && shift_evt && (nbits == CNTW'(W - 1));
    assign active   = active_q;
    assign rx_data  = rx_q;

    // Buffer load, bit sampling, shifting and end-of-byte capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sbuf     <= '0;
            rx_q     <= '0;
            nbits    <= '0;
            samp     <= 1'b0;
            active_q <= 1'b0;
        end else begin
            if (load && !active_q)
                sbuf <= load_data;
            if (abort) begin
                active_q <= 1'b0;
                nbits    <= '0;
            end else begin
                if (start)
                    active_q <= 1'b1;
                if (sample_evt) begin
                    samp     <= sample_in;
                    active_q <= 1'b1;
                end
                if (shift_evt && active_q) begin
                    sbuf <= shifted;
                    if (done_evt) begin
                        nbits    <= '0;
                        active_q <= 1'b0;
                        rx_q     <= shifted;
                    end else begin
                        nbits <= nbits + CNTW'(1);
                    end
                end
            end
        end
    end

    // R9: the buffer only moves on a shift while a byte is in flight
    a_r9_hold_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !shift_evt) |=> $stable(sbuf));

    // R8: the last shift ends the byte
    a_r8_byte_end: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> !active_q);

endmodule

// File: rtl/spi_xfer_unit.sv
// Register-mapped serial port, master or slave, clock mode 0.
// Holds the control register and the master SCK phase. It routes events
// from the divider or the synchronizer into the shifter and drives the pins
// with their enables. Assumes the CPU port is synchronous to clk.
module spi_xfer_unit
    import spi_xfer_pkg::*;
#(
    parameter int PRESCALE    = 4,
    parameter int DIV_MID     = 4,
    parameter int DIV_SLOW    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic             bus_sel,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             sck_i,
    output logic             sck_o,
    output logic             sck_oe,
    input  logic             scs_i,
    output logic             scs_o,
    output logic             scs_oe,
    input  logic             sdi_i,
    output logic             sdo_o,
    output logic             sdo_oe
);
    spi_ctrl_t        ctrl_q;
    spi_ctrl_t        wr_view;
    logic             is_slave, wr_ctrl, wr_data, busy, master_run;
    logic             tick, sck_q, m_rise, m_fall;
    logic             s_rise, s_fall, scs_sync, slave_sel, slave_on;
    logic             sample_evt, shift_evt, start, load, abort, done_evt, out_bit;
    logic [REG_W-1:0] rx_data;

    assign wr_view    = spi_ctrl_t'(bus_wdata);
    assign is_slave   = (ctrl_q.mode == MODE_SLAVE);
    assign wr_ctrl    = bus_we && !bus_sel;
    assign wr_data    = bus_we && bus_sel;
    assign master_run = busy && !is_slave;

    spi_xfer_clkdiv #(
        .PRESCALE (PRESCALE),
        .DIV_MID  (DIV_MID),
        .DIV_SLOW (DIV_SLOW)
    ) i_clkdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (master_run),
        .clk_fast (ctrl_q.clk_fast),
        .mode     (ctrl_q.mode),
        .tick     (tick)
    );

    spi_xfer_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_raw   (sck_i),
        .scs_raw   (scs_i),
        .sck_rise  (s_rise),
        .sck_fall  (s_fall),
        .scs_level (scs_sync)
    );

    // Master SCK phase: toggles on each divider tick while a transfer runs
    always_ff @(posedge clk) begin
        if (!rst_n)
            sck_q <= 1'b0;
        else if (!master_run)
            sck_q <= 1'b0;
        else if (tick)
            sck_q <= !sck_q;
    end

    assign m_rise     = tick && !sck_q;
    assign m_fall     = tick &&  sck_q;
    assign slave_sel  = !ctrl_q.sel_en || !scs_sync;
    assign slave_on   = ctrl_q.bus_en && is_slave && slave_sel;
    assign sample_evt = is_slave ? (slave_on && s_rise) : m_rise;
    assign shift_evt  = is_slave ? (slave_on && s_fall) : m_fall;
    assign load       = wr_data && !busy;
    assign start      = load && ctrl_q.bus_en && !is_slave;
    assign abort      = !ctrl_q.bus_en;

    spi_xfer_shifter #(
        .W (REG_W)
    ) i_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (abort),
        .load       (load),
        .load_data  (bus_wdata),
        .start      (start),
        .msb_first  (ctrl_q.msb_first),
        .sample_evt (sample_evt),
        .sample_in  (sdi_i),
        .shift_evt  (shift_evt),
        .out_bit    (out_bit),
        .active     (busy),
        .done_evt   (done_evt),
        .rx_data    (rx_data)
    );

    // Control register: CPU writes, clear-by-zero flags, flag sets win
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= spi_ctrl_t'(CTRL_RESET);
        end else begin
            if (wr_ctrl) begin
                ctrl_q.clk_fast  <= wr_view.clk_fast;
                ctrl_q.mode      <= wr_view.mode;
                ctrl_q.bus_en    <= wr_view.bus_en;
                ctrl_q.msb_first <= wr_view.msb_first;
                ctrl_q.sel_en    <= wr_view.sel_en;
                if (!wr_view.collide) ctrl_q.collide <= 1'b0;
                if (!wr_view.done)    ctrl_q.done    <= 1'b0;
            end
            if (wr_data && busy)
                ctrl_q.collide <= 1'b1;
            if (done_evt)
                ctrl_q.done <= 1'b1;
        end
    end

    assign bus_rdata = bus_sel ? rx_data : ctrl_q;
    assign sck_o     = sck_q;
    assign sck_oe    = ctrl_q.bus_en && !is_slave;
    assign scs_o     = !busy;
    assign scs_oe    = ctrl_q.bus_en && !is_slave && ctrl_q.sel_en;
    assign sdo_o     = out_bit;
    assign sdo_oe    = ctrl_q.bus_en && (!is_slave || slave_sel);

    // R6: a disabled port ends any transfer and releases every pin
    a_r6_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.bus_en |=> !busy);
    a_r6_pins_float: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.bus_en |-> (!sck_oe && !sdo_oe && !scs_oe));

    // R9: a data write into a running transfer raises the collision flag
    a_r9_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && busy) |=> ctrl_q.collide);

    // R8: the end of a byte raises the complete flag
    a_r8_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> (ctrl_q.done && !busy));

    // R3: SCK returns low whenever no master transfer runs
    a_r3_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !master_run |=> !sck_o);

    // R13: a deselected slave leaves SDO floating
    a_r13_sdo_float: assert property (@(posedge clk) disable iff (!rst_n)
        (is_slave && ctrl_q.sel_en && scs_sync) |-> !sdo_oe);

endmodule

// File: tb/test_spi_xfer_unit.sv
// Bench: behavioural master model compared every clock, directed slave tests.
module test_spi_xfer_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, bus_we, bus_sel;
    logic [7:0] bus_wdata, bus_rdata;
    logic       sck_s, scs_s, sdi_s, sdi_m, sdi_i;
    logic       sck_o, sck_oe, scs_o, scs_oe, sdo_o, sdo_oe;
    bit         track;
    int         checks = 0;
    int         errors = 0;

    logic [7:0] m_ctrl, m_pre, m_tx, m_pat;
    bit         m_busy, pre_busy;
    int         m_t, m_half;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sdi_i = track ? sdi_m : sdi_s;

    spi_xfer_unit i_spi_xfer_unit (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_i(sck_s), .sck_o(sck_o), .sck_oe(sck_oe),
        .scs_i(scs_s), .scs_o(scs_o), .scs_oe(scs_oe),
        .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int half_len(input logic [7:0] c);
        int pre;
        int div;
        pre = c[7] ? 1 : 4;
        div = (c[6:5] == 2'b00) ? 1 : (c[6:5] == 2'b01) ? 4 : 16;
        return pre * div;
    endfunction

    // Reference model of the register file and master transfer, then comparison
    always @(posedge clk) begin
        m_pre    = m_ctrl;
        pre_busy = m_busy;
        if (!rst_n) begin
            m_ctrl = 8'h60;
            m_busy = 0;
            m_t    = 0;
        end else begin
            if (bus_we && !bus_sel) begin
                m_ctrl[7:2] = bus_wdata[7:2];
                if (!bus_wdata[1]) m_ctrl[1] = 1'b0;
                if (!bus_wdata[0]) m_ctrl[0] = 1'b0;
            end
            if (bus_we && bus_sel) begin
                if (pre_busy) begin
                    m_ctrl[1] = 1'b1;
                end else begin
                    m_tx = bus_wdata;
                    if (m_pre[4] && m_pre[6:5] != 2'b11) begin
                        m_busy = 1;
                        m_t    = 0;
                        m_half = half_len(m_pre);
                    end
                end
            end
            if (pre_busy) begin
                m_t++;
                if (m_t == 16 * m_half) begin
                    m_busy    = 0;
                    m_ctrl[0] = 1'b1;
                end
            end
        end
        #(CLK_PERIOD/4);
        if (track && rst_n) begin
            if (!bus_sel) check("R2 control readback", 32'(bus_rdata), 32'(m_ctrl));
            check("R6 sck enable", 32'(sck_oe), 32'(m_ctrl[4] && m_ctrl[6:5] != 2'b11));
            check("R6 select enable", 32'(scs_oe), 32'(m_ctrl[4] && m_ctrl[6:5] != 2'b11 && m_ctrl[2]));
            check("R3 sck level", 32'(sck_o), m_busy ? 32'((m_t / m_half) % 2) : 32'd0);
            if (m_ctrl[4] && m_ctrl[2]) check("R7 select level", 32'(scs_o), 32'(!m_busy));
            if (m_busy) begin
                int idx;
                idx = m_t / (2 * m_half);
                check("R5 sdo bit", 32'(sdo_o), 32'(m_ctrl[3] ? m_tx[7 - idx] : m_tx[idx]));
                sdi_m = m_ctrl[3] ? m_pat[7 - idx] : m_pat[idx];
            end
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        @(negedge clk);
        bus_sel = sel;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic master_byte(input logic [7:0] ctrl, input logic [7:0] tx, input logic [7:0] pat);
        logic [7:0] rv;
        wr(1'b0, ctrl);
        m_pat = pat;
        wr(1'b1, tx);
        repeat (16 * half_len(ctrl) + 4) @(negedge clk);
        rd(1'b1, rv);
        check("R4 R8 received byte", 32'(rv), 32'(pat));
        rd(1'b0, rv);
        check("R8 complete flag", 32'(rv[0]), 32'd1);
    endtask

    task automatic slave_byte(input logic [7:0] tx, input logic [7:0] pat, input bit msb, input bit chk);
        for (int i = 0; i < 8; i++) begin
            int idx;
            idx = msb ? 7 - i : i;
            sdi_s = pat[idx];
            repeat (8) @(negedge clk);
            if (chk) check("R12 slave sdo bit", 32'(sdo_o), 32'(tx[idx]));
            sck_s = 1'b1;
            repeat (8) @(negedge clk);
            sck_s = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    initial begin
        logic [7:0] rv;
        rst_n = 0; bus_we = 0; bus_sel = 0; bus_wdata = 0;
        sck_s = 0; scs_s = 1; sdi_s = 0; sdi_m = 0; track = 0;
        m_tx = 0; m_pat = 0; m_half = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd(1'b0, rv);
        check("R1 reset control", 32'(rv), 32'h60);
        check("R1 reset enables", 32'({sck_oe, sdo_oe, scs_oe}), 32'd0);

        track = 1;
        // Fastest master, MSB first, select on
        master_byte(8'h9C, 8'hA5, 8'h3C);
        // Prescaled, divider 4, LSB first
        master_byte(8'h34, 8'h81, 8'hC6);
        // Slowest divider with prescale, no select
        master_byte(8'h58, 8'h3C, 8'hA5);

        // R9: collision mid-transfer is flagged and discarded
        wr(1'b0, 8'hDC);
        m_pat = 8'h99;
        wr(1'b1, 8'h5A);
        repeat (40) @(negedge clk);
        wr(1'b1, 8'hFF);
        repeat (16 * 16) @(negedge clk);
        rd(1'b1, rv);
        check("R9 transfer unaffected", 32'(rv), 32'h99);
        rd(1'b0, rv);
        check("R9 collision flag", 32'(rv[1:0]), 32'd3);

        // R10: writing ones keeps flags, zeros clear them
        wr(1'b0, 8'hDF);
        rd(1'b0, rv);
        check("R10 flags kept", 32'(rv), 32'hDF);
        wr(1'b0, 8'hDC);
        rd(1'b0, rv);
        check("R10 flags cleared", 32'(rv), 32'hDC);

        // R11: disabled port loads but does not start
        wr(1'b0, 8'h8C);
        wr(1'b1, 8'h80);
        repeat (20) @(negedge clk);
        rd(1'b0, rv);
        check("R11 no transfer", 32'(rv), 32'h8C);
        check("R6 disabled enables", 32'({sck_oe, sdo_oe, scs_oe}), 32'd0);
        wr(1'b0, 8'h9C);
        repeat (2) @(negedge clk);
        check("R11 buffer loaded", 32'(sdo_o), 32'd1);
        check("R11 still idle", 32'(sck_o), 32'd0);

        // R12: slave, no select, MSB first
        track = 0;
        wr(1'b0, 8'h78);
        wr(1'b1, 8'h5A);
        check("R12 slave sck not driven", 32'(sck_oe), 32'd0);
        check("R12 slave sdo driven", 32'(sdo_oe), 32'd1);
        slave_byte(8'h5A, 8'h3C, 1'b1, 1'b1);
        rd(1'b0, rv);
        check("R12 slave complete", 32'(rv), 32'h79);
        rd(1'b1, rv);
        check("R12 slave received", 32'(rv), 32'h3C);

        // R13: select enabled, deselected edges ignored
        wr(1'b0, 8'h74);
        repeat (5) @(negedge clk);
        check("R13 sdo floats", 32'(sdo_oe), 32'd0);
        wr(1'b1, 8'hC3);
        slave_byte(8'hC3, 8'hFF, 1'b0, 1'b0);
        rd(1'b0, rv);
        check("R13 no completion", 32'(rv), 32'h74);
        scs_s = 1'b0;
        repeat (5) @(negedge clk);
        check("R13 sdo driven when selected", 32'(sdo_oe), 32'd1);
        slave_byte(8'hC3, 8'h96, 1'b0, 1'b1);
        rd(1'b1, rv);
        check("R13 selected byte received", 32'(rv), 32'h96);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule